// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a simple internal request port and an external asynchronous static RAM of 64K words by 16 bits. A single request carries a direction flag, a word address, write data and a two-bit lane mask. The controller turns each request into a pin-level access. It drives the chip select, write strobe and read strobe, plus one active-low enable for each byte lane. It drives the data pins through a separate output value and output-enable pair. A one-clock completion pulse ends every request, and a read also returns the sampled word.

All timing is counted in system clocks. One parameter sets how long a read holds its strobes before the data is sampled. A second sets how long the write strobe stays low. Between requests the memory is parked in standby with chip select high. Data is written on the rising edge of the write strobe. The data pins are never driven while the memory itself may be driving them.

Top module: `srambus_top`

## Requirements
- R1: After reset and whenever no request is in progress, memCeN, memWeN and memOeN are all high and memDataOe is low.
- R2: A read holds memCeN low, memWeN high and memOeN low for exactly RD_WAIT clocks, and memDataOe stays low throughout.
- R3: Read data is sampled on the last read clock. Mask bit 0 selects the lower lane (bits 7:0) and mask bit 1 selects the upper lane (bits 15:8). Each lane's active-low byte enable is low during the access only if its mask bit is 1, and a lane whose mask bit is 0 returns zero in respData.
- R4: A write runs as follows. First comes one setup clock with memCeN low and both strobes high. Then memWeN is low for WR_PULSE clocks with the data driven. Then comes one hold clock with memWeN high and the data still driven, so the memory captures it on the rising edge of memWeN.
- R5: A write changes only the lanes whose mask bit is 1. The other lane of the addressed word keeps its earlier value.
- R6: respDone is high for exactly one clock, in the cycle after the last access clock. Counted in rising edges from the accepting edge to the first edge after which respDone is seen high, this is RD_WAIT+1 for a read and WR_PULSE+3 for a write.
- R7: memDataOe is never high while memCeN is low, memWeN is high and memOeN is low. The clock that follows any clock with memOeN low has memDataOe low.
- R8: A request with mask 00 completes with respDone one clock after acceptance, and memCeN, memWeN and memOeN stay high throughout.
- R9: A request is accepted only when the controller is idle. reqValid asserted while an access is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Lane mask, bit0 lower byte, bit1 upper byte |
| respData | output | 16 | Read data, unselected lane zero |
| respDone | output | 1 | One-clock completion pulse |
| memCeN | output | 1 | Memory chip select, active low |
| memWeN | output | 1 | Memory write strobe, active low |
| memOeN | output | 1 | Memory read strobe, active low |
| memLbN | output | 1 | Lower lane enable, active low |
| memUbN | output | 1 | Upper lane enable, active low |
| memAddr | output | 16 | Memory address |
| memDataOut | output | 16 | Value for the data pins |
| memDataOe | output | 1 | Drive enable for the data pins |
| memDataIn | input | 16 | Value sampled from the data pins |

## Verification
The tests issue full-word, lower-only, upper-only and empty-mask requests against a behavioural memory model that writes on the rising edge of the write strobe. A partial write followed by a full read shows whether the other lane was left untouched. A partial read shows whether the unselected lane is zeroed. A read followed at once by a write exercises bus turnaround. A request raised mid-access shows that such requests are ignored. Latency counts tell the read, write and empty-mask paths apart.

// File: rtl/srambus_pkg.sv
package srambus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_FINISH
  } state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic chip;
    logic wrStrobe;
    logic rdStrobe;
    logic drive;
    logic capture;
  } strobe_t;

endpackage

// File: rtl/srambus_fsm.sv
module srambus_fsm
  import srambus_pkg::*;
#(
  parameter int RD_WAIT  = 4,
  parameter int WR_PULSE = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic [1:0] reqMask,
  output strobe_t stb,
  output logic    respDone
);

  localparam int MAXW = (RD_WAIT > WR_PULSE) ? RD_WAIT : WR_PULSE;
  localparam int CW = (MAXW > 1) ? $clog2(MAXW) : 1;
  localparam logic [CW-1:0] RD_LAST = CW'(RD_WAIT - 1);
  localparam logic [CW-1:0] WR_LAST = CW'(WR_PULSE - 1);

  state_t state, stateNext;
  logic [CW-1:0] cnt;
  logic accept;

  assign accept = (state == ST_IDLE) && reqValid;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (reqValid) begin
                   if (reqMask == 2'b00) stateNext = ST_FINISH;
                   else if (reqWrite)    stateNext = ST_WSETUP;
                   else                  stateNext = ST_READ;
                 end
      ST_READ:   if (cnt == RD_LAST) stateNext = ST_FINISH;
      ST_WSETUP: stateNext = ST_WPULSE;
      ST_WPULSE: if (cnt == WR_LAST) stateNext = ST_WHOLD;
      ST_WHOLD:  stateNext = ST_FINISH;
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      if (state != stateNext) cnt <= '0;
      else if (state == ST_READ || state == ST_WPULSE) cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    stb          = '0;
    stb.load     = accept;
    stb.chip     = (state == ST_READ) || (state == ST_WSETUP) ||
                   (state == ST_WPULSE) || (state == ST_WHOLD);
    stb.wrStrobe = (state == ST_WPULSE);
    stb.rdStrobe = (state == ST_READ);
    stb.drive    = (state == ST_WPULSE) || (state == ST_WHOLD);
    stb.capture  = (state == ST_READ) && (cnt == RD_LAST);
  end

  assign respDone = (state == ST_FINISH);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    respDone |=> !respDone); // R6
  AST_EMPTY_MASK_FAST: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqMask == 2'b00) |=> respDone); // R8
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> !stb.load || $past(state) == ST_FINISH); // R9

endmodule

// File: rtl/srambus_datapath.sv
module srambus_datapath
  import srambus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdata,
  input  logic [1:0]    reqMask,
  input  logic [DW-1:0] memDataIn,
  output logic [DW-1:0] respData,
  output logic          memCeN,
  output logic          memWeN,
  output logic          memOeN,
  output logic          memLbN,
  output logic          memUbN,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memDataOut,
  output logic          memDataOe
);

  localparam int HALF = DW / 2;

  logic [AW-1:0] addrReg;
  logic [DW-1:0] wdataReg;
  logic [1:0]    maskReg;
  logic [DW-1:0] laneKeep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      maskReg  <= '0;
    end else if (stb.load) begin
      addrReg  <= reqAddr;
      wdataReg <= reqWdata;
      maskReg  <= reqMask;
    end
  end

  assign laneKeep = {{HALF{maskReg[1]}}, {HALF{maskReg[0]}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            respData <= '0;
    else if (stb.capture) respData <= memDataIn & laneKeep;
  end

  assign memCeN     = !stb.chip;
  assign memWeN     = !stb.wrStrobe;
  assign memOeN     = !stb.rdStrobe;
  assign memLbN     = !(stb.chip && maskReg[0]);
  assign memUbN     = !(stb.chip && maskReg[1]);
  assign memAddr    = addrReg;
  assign memDataOut = wdataReg;
  assign memDataOe  = stb.drive;

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rstN)
    memDataOe |-> !(!memCeN && memWeN && !memOeN)); // R7
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |=> !memDataOe); // R7
  AST_WE_WITH_CE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCeN && memOeN)); // R4
  AST_DRIVE_AT_WE_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (memDataOe && !memCeN)); // R4
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memWeN && !memDataOe)); // R2

endmodule

// File: rtl/srambus_top.sv
module srambus_top
  import srambus_pkg::*;
#(
  parameter int RD_WAIT  = 4,
  parameter int WR_PULSE = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [15:0] reqAddr,
  input  logic [15:0] reqWdata,
  input  logic [1:0]  reqMask,
  output logic [15:0] respData,
  output logic        respDone,
  output logic        memCeN,
  output logic        memWeN,
  output logic        memOeN,
  output logic        memLbN,
  output logic        memUbN,
  output logic [15:0] memAddr,
  output logic [15:0] memDataOut,
  output logic        memDataOe,
  input  logic [15:0] memDataIn
);

  strobe_t stb;

  srambus_fsm #(.RD_WAIT(RD_WAIT), .WR_PULSE(WR_PULSE)) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqMask(reqMask), .stb(stb), .respDone(respDone)
  );

  srambus_datapath #(.AW(16), .DW(16)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqMask(reqMask), .memDataIn(memDataIn),
    .respData(respData), .memCeN(memCeN), .memWeN(memWeN),
    .memOeN(memOeN), .memLbN(memLbN), .memUbN(memUbN),
    .memAddr(memAddr), .memDataOut(memDataOut), .memDataOe(memDataOe)
  );

  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rstN)
    respDone |-> (memCeN && memWeN && memOeN && !memDataOe)); // R1

endmodule

// File: tb/srambus_top_bench.sv
`timescale 1ns/1ps
module srambus_top_bench;

  localparam int RDW = 4;
  localparam int WRP = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0, reqWdata = '0;
  logic [1:0] reqMask = '0;
  logic [15:0] respData, memAddr, memDataOut, memDataIn;
  logic respDone, memCeN, memWeN, memOeN, memLbN, memUbN, memDataOe;

  int checks = 0;
  int failures = 0;
  int contention = 0;
  int cycles = 0;
  int weLowSeen = 0, oeLowSeen = 0, ceLowSeen = 0;
  int oeLowRun = 0, maxOeRun = 0;
  logic lastOeLow = 1'b0;
  logic [15:0] mem [16];

  always #2 clk = ~clk;

  srambus_top #(.RD_WAIT(RDW), .WR_PULSE(WRP)) u_srambus_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .respData(respData), .respDone(respDone), .memCeN(memCeN),
    .memWeN(memWeN), .memOeN(memOeN), .memLbN(memLbN), .memUbN(memUbN),
    .memAddr(memAddr), .memDataOut(memDataOut), .memDataOe(memDataOe),
    .memDataIn(memDataIn)
  );

  // memory model: lanes driven only when selected, write on write-strobe rise
  wire rdOn = (memCeN === 1'b0) && (memWeN === 1'b1) && (memOeN === 1'b0);
  assign memDataIn[7:0]  = (rdOn && memLbN === 1'b0) ? mem[memAddr[3:0]][7:0]  : 8'hzz;
  assign memDataIn[15:8] = (rdOn && memUbN === 1'b0) ? mem[memAddr[3:0]][15:8] : 8'hzz;

  always @(posedge memWeN) begin
    if (memCeN === 1'b0) begin
      if (memDataOe !== 1'b1) contention++;
      if (memLbN === 1'b0) mem[memAddr[3:0]][7:0]  <= memDataOut[7:0];
      if (memUbN === 1'b0) mem[memAddr[3:0]][15:8] <= memDataOut[15:8];
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      if (memDataOe && !memCeN && memWeN && !memOeN) contention++;
      if (lastOeLow && memDataOe) contention++;
      lastOeLow = !memOeN;
      if (!memWeN) weLowSeen++;
      if (!memOeN) begin oeLowSeen++; oeLowRun++; end
      else oeLowRun = 0;
      if (oeLowRun > maxOeRun) maxOeRun = oeLowRun;
      if (!memCeN) ceLowSeen++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // issue one request, return edges until done is seen
  task automatic runReq(input bit wr, input logic [15:0] a, input logic [15:0] d,
                        input logic [1:0] m, output int lat);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    weLowSeen = 0; oeLowSeen = 0; ceLowSeen = 0; maxOeRun = 0;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!respDone && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    @(negedge clk);
    check(!respDone, "R6 done single pulse", respDone, 0);
  endtask

  task automatic testReset();
    check(memCeN && memWeN && memOeN && !memDataOe, "R1 reset idle",
          {memCeN, memWeN, memOeN, memDataOe}, 4'b1110);
    check(!respDone, "R1 no done at reset", respDone, 0);
  endtask

  task automatic testFullWord();
    int lat;
    runReq(1'b1, 16'h0003, 16'hA55A, 2'b11, lat);
    check(lat == WRP + 3, "R6 write latency", lat, WRP + 3);
    check(weLowSeen == WRP, "R4 write strobe width", weLowSeen, WRP);
    check(mem[3] == 16'hA55A, "R4 word written", mem[3], 16'hA55A);
    check(memCeN && memWeN && memOeN && !memDataOe, "R1 idle after write",
          {memCeN, memWeN, memOeN, memDataOe}, 4'b1110);
    runReq(1'b0, 16'h0003, 16'h0, 2'b11, lat);
    check(lat == RDW + 1, "R6 read latency", lat, RDW + 1);
    check(maxOeRun == RDW && weLowSeen == 0, "R2 read strobe window", maxOeRun, RDW);
    check(respData == 16'hA55A, "R3 full read", respData, 16'hA55A);
  endtask

  task automatic testLanes();
    int lat;
    mem[5] = 16'h1234;
    runReq(1'b1, 16'h0005, 16'hFFCD, 2'b01, lat);
    check(mem[5] == 16'h12CD, "R5 lower-only write", mem[5], 16'h12CD);
    runReq(1'b1, 16'h0005, 16'h77FF, 2'b10, lat);
    check(mem[5] == 16'h77CD, "R5 upper-only write", mem[5], 16'h77CD);
    runReq(1'b0, 16'h0005, 16'h0, 2'b11, lat);
    check(respData == 16'h77CD, "R5 read back merged", respData, 16'h77CD);
    runReq(1'b0, 16'h0005, 16'h0, 2'b01, lat);
    check(respData == 16'h00CD, "R3 lower-only read", respData, 16'h00CD);
    runReq(1'b0, 16'h0005, 16'h0, 2'b10, lat);
    check(respData == 16'h7700, "R3 upper-only read", respData, 16'h7700);
  endtask

  task automatic testEmptyMask();
    int lat;
    mem[7] = 16'hBEEF;
    runReq(1'b1, 16'h0007, 16'h0000, 2'b00, lat);
    check(lat == 1, "R8 empty write latency", lat, 1);
    check(weLowSeen == 0 && oeLowSeen == 0 && ceLowSeen == 0, "R8 no strobes",
          weLowSeen + oeLowSeen + ceLowSeen, 0);
    check(mem[7] == 16'hBEEF, "R8 memory untouched", mem[7], 16'hBEEF);
    runReq(1'b0, 16'h0007, 16'h0000, 2'b00, lat);
    check(lat == 1 && oeLowSeen == 0, "R8 empty read", lat, 1);
  endtask

  task automatic testTurnaround();
    int lat;
    runReq(1'b0, 16'h0003, 16'h0, 2'b11, lat);
    runReq(1'b1, 16'h0004, 16'h4444, 2'b11, lat);
    check(mem[4] == 16'h4444, "R7 write after read", mem[4], 16'h4444);
    check(contention == 0, "R7 no bus fight", contention, 0);
  endtask

  task automatic testBusyIgnore();
    int lat;
    mem[9] = 16'h9999;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 16'h0003; reqMask = 2'b11;
    @(posedge clk);
    @(negedge clk);
    reqWrite = 1'b1; reqAddr = 16'h0009; reqWdata = 16'h0000;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 0;
    while (!respDone && lat < 60) begin @(negedge clk); lat++; end
    check(respData == 16'hA55A, "R9 first read intact", respData, 16'hA55A);
    ceLowSeen = 0;
    repeat (12) @(negedge clk);
    check(ceLowSeen == 0, "R9 no extra access", ceLowSeen, 0);
    check(mem[9] == 16'h9999, "R9 busy request dropped", mem[9], 16'h9999);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testFullWord();
    testLanes();
    testEmptyMask();
    testTurnaround();
    testBusyIgnore();
    check(contention == 0, "R7 contention overall", contention, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 5000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule